// File: doc/BRIEF.md
# L1 Reverse Directory Entry Writer

This block holds a reverse directory that records, for every L1 cache line that holds a copy of an L2 line, where that copy came from. Storage is split by side (instruction or data), then by L2 bank, then by row and panel. Each array holds one 16-bit entry per (core, L1 way, address bit 4) slot. A fill request carries a 40-bit physical address, a core ID, an L1 way, an L2 way and a side select. From these the block forms the L2 set index, the 13-bit directory tag, a parity bit and the entry slot. It then writes the entry in the same clock edge.

How the address is cut depends on how many L2 banks are active. A 4-bit enable mask turns banks on in pairs. With fewer active banks, fewer address bits pick the bank, so the set index slides down the address. The block also clears a single entry's valid bit, and can clear every valid bit on both sides in one cycle. A registered read port returns any stored entry, and flags a parity error when the stored parity does not match the stored tag and address bit.

Top module: `l1_rev_dir`

## Requirements
- R1: A written entry reads back as {valid=1 at bit 15, parity at bit 14, address bit 4 at bit 13, tag at bits 12:0}. The tag is the 9-bit L2 set index placed above the 4-bit L2 way.
- R2: The stored parity equals the XOR of the 13 tag bits and address bit 4. `rdParErr` is high only for a valid entry whose stored parity differs from that XOR, so it stays low for every entry the block wrote.
- R3: When the bank mask has 4, 3 or 0 bits set (full interleave), the bank is addr[8:6] and the set index is addr[17:9].
- R4: When exactly 2 mask bits are set, the bank is {pair, addr[6]}. The pair is the lower-numbered set mask bit when addr[7]=0 and the higher one when addr[7]=1. The set index is addr[16:8].
- R5: When exactly 1 mask bit is set, the bank is {that bit's position, addr[6]} and the set index is addr[15:7].
- R6: The request picks the side from `reqIside` (1 = instruction), the row from addr[5] and the panel from addr[10:9]. The slot within the array is {core ID, L1 way, addr[4]}, with addr[4] in the least significant bit. Address bits 5:0 play no part in the tag or set index.
- R7: A write changes only the addressed entry. Every other entry keeps its contents.
- R8: A per-entry invalidate clears only that entry's valid bit. Its parity, address-bit-4 and tag fields still read back. If a write targets the same entry in the same cycle, the write wins.
- R9: `invAll` clears every valid bit on both sides in one cycle. It also suppresses any write or per-entry invalidate in that cycle.
- R10: Read data appears one cycle after the read address is presented. It shows the contents from before that clock edge's update.
- R11: After reset, every entry reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bankMask | input | 4 | Bank-pair enable mask; the number of set bits picks the interleave mode |
| reqValid | input | 1 | Fill request strobe |
| reqAddr | input | 40 | Physical address of the fill |
| reqCore | input | CORE_W (1) | Requesting core ID |
| reqL1Way | input | 2 | L1 way being filled |
| reqL2Way | input | 4 | L2 way holding the line |
| reqIside | input | 1 | 1 = instruction directory, 0 = data directory |
| invAll | input | 1 | Clear all valid bits |
| invValid | input | 1 | Per-entry invalidate strobe |
| invIside | input | 1 | Side of the entry to invalidate |
| invBank | input | 3 | Bank of the entry to invalidate |
| invRow | input | 1 | Row of the entry to invalidate |
| invPanel | input | 2 | Panel of the entry to invalidate |
| invEntry | input | CORE_W+3 (4) | Slot of the entry to invalidate |
| rdIside | input | 1 | Side to read |
| rdBank | input | 3 | Bank to read |
| rdRow | input | 1 | Row to read |
| rdPanel | input | 2 | Panel to read |
| rdEntry | input | CORE_W+3 (4) | Slot to read |
| rdData | output | 16 | Registered entry contents |
| rdParErr | output | 1 | Registered parity-mismatch flag for a valid entry |

## Verification
The bench builds the block with its default parameters: a 40-bit address, a 1-bit core ID, 2-bit L1 ways, 4-bit L2 ways and a 9-bit set index. That gives 128 arrays of 16 slots, so every slot of an array can be swept and cross-checked against a shadow model. The stimulus covers all three interleave modes, including the 3-set and 0-set masks that fall back to full interleave. For each mode it also checks the place where full interleave would have put the entry, which exposes any mix-up between the index shifts. Directed cases cover same-cycle conflicts: a write against an invalidate, a write against `invAll`, and a read against a write to the same slot.

// File: rtl/l1_rev_dir_pkg.sv
package l1_rev_dir_pkg;

  // Strobes passed from the control decoder to the storage datapath.
  typedef struct packed {
    logic wrEn;    // write the decoded entry
    logic invEn;   // clear one valid bit
    logic clrAll;  // clear every valid bit
  } dir_strobe_t;

  localparam int LINE_W    = 6;  // 64-byte line offset
  localparam int PANEL_LSB = 9;  // panel select sits at addr[10:9]

endpackage

// File: rtl/l1_rev_dir_ctrl.sv
module l1_rev_dir_ctrl
  import l1_rev_dir_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int CORE_W  = 1,
  parameter int L1WAY_W = 2,
  parameter int L2WAY_W = 4,
  parameter int SET_W   = 9,
  parameter int MASK_W  = 4
) (
  input  logic [MASK_W-1:0]                  bankMask,
  input  logic                               reqValid,
  input  logic [ADDR_W-1:0]                  reqAddr,
  input  logic [CORE_W-1:0]                  reqCore,
  input  logic [L1WAY_W-1:0]                 reqL1Way,
  input  logic [L2WAY_W-1:0]                 reqL2Way,
  input  logic                               reqIside,
  input  logic                               invAll,
  input  logic                               invValid,
  output dir_strobe_t                        strobes,
  output logic [$clog2(MASK_W)+1-1:0]        wrBank,
  output logic                               wrRow,
  output logic [1:0]                         wrPanel,
  output logic [CORE_W+L1WAY_W:0]            wrSlot,
  output logic [SET_W+L2WAY_W+2:0]           wrWord
);

  localparam int PAIR_W = $clog2(MASK_W);
  localparam int BANK_W = PAIR_W + 1;
  localparam int TAG_W  = SET_W + L2WAY_W;
  localparam int CNT_W  = $clog2(MASK_W + 1);

  logic [CNT_W-1:0]  setCnt;
  logic [PAIR_W-1:0] lowPair;
  logic [PAIR_W-1:0] highPair;
  logic              foundLow;
  logic [ADDR_W-1:0] alignedAddr;
  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagBits;
  logic              addrBit4;
  logic              parBit;

  // Count enabled bank pairs and find the lowest and highest one.
  always_comb begin
    setCnt   = '0;
    lowPair  = '0;
    highPair = '0;
    foundLow = 1'b0;
    for (int i = 0; i < MASK_W; i++) begin
      if (bankMask[i]) begin
        setCnt = setCnt + 1'b1;
        if (!foundLow) begin
          lowPair  = PAIR_W'(i);
          foundLow = 1'b1;
        end
        highPair = PAIR_W'(i);
      end
    end
  end

  assign alignedAddr = {reqAddr[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
  assign addrBit4    = reqAddr[LINE_W-2];

  // Bank and set index depend on the interleave mode.
  always_comb begin
    if (setCnt == CNT_W'(1)) begin
      wrBank = {lowPair, alignedAddr[LINE_W]};
      setIdx = alignedAddr[LINE_W+1 +: SET_W];
    end else if (setCnt == CNT_W'(2)) begin
      wrBank = {(alignedAddr[LINE_W+1] ? highPair : lowPair), alignedAddr[LINE_W]};
      setIdx = alignedAddr[LINE_W+2 +: SET_W];
    end else begin
      wrBank = alignedAddr[LINE_W +: BANK_W];
      setIdx = alignedAddr[LINE_W+BANK_W +: SET_W];
    end
  end

  assign wrRow   = reqAddr[LINE_W-1];
  assign wrPanel = alignedAddr[PANEL_LSB +: 2];
  assign wrSlot  = {reqCore, reqL1Way, addrBit4};

  assign tagBits = {setIdx, reqL2Way};
  assign parBit  = (^tagBits) ^ addrBit4;
  assign wrWord  = {1'b1, parBit, addrBit4, tagBits};

  // invAll has priority over both the write and the single invalidate.
  always_comb begin
    strobes.clrAll = invAll;
    strobes.wrEn   = reqValid & ~invAll;
    strobes.invEn  = invValid & ~invAll;
  end

endmodule

// File: rtl/l1_rev_dir_store.sv
module l1_rev_dir_store
  import l1_rev_dir_pkg::*;
#(
  parameter int LOC_W = 11,
  parameter int TAG_W = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  dir_strobe_t        strobes,
  input  logic [LOC_W-1:0]   wrLoc,
  input  logic [TAG_W+2:0]   wrWord,
  input  logic [LOC_W-1:0]   invLoc,
  input  logic [LOC_W-1:0]   rdLoc,
  output logic [TAG_W+2:0]   rdData,
  output logic               rdParErr,
  output logic [(1<<LOC_W)-1:0] validBits
);

  localparam int NLOC = 1 << LOC_W;

  logic [NLOC-1:0]  parBits;
  logic [NLOC-1:0]  a4Bits;
  logic [TAG_W-1:0] tagMem [NLOC];

  logic             rdValid;
  logic             rdPar;
  logic             rdA4;
  logic [TAG_W-1:0] rdTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
      parBits   <= '0;
      a4Bits    <= '0;
      for (int i = 0; i < NLOC; i++) tagMem[i] <= '0;
    end else begin
      if (strobes.clrAll) validBits <= '0;
      if (strobes.invEn)  validBits[invLoc] <= 1'b0;
      // Write comes last so it wins over an invalidate of the same entry.
      if (strobes.wrEn) begin
        validBits[wrLoc] <= wrWord[TAG_W+2];
        parBits[wrLoc]   <= wrWord[TAG_W+1];
        a4Bits[wrLoc]    <= wrWord[TAG_W];
        tagMem[wrLoc]    <= wrWord[TAG_W-1:0];
      end
    end
  end

  assign rdValid = validBits[rdLoc];
  assign rdPar   = parBits[rdLoc];
  assign rdA4    = a4Bits[rdLoc];
  assign rdTag   = tagMem[rdLoc];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      rdParErr <= 1'b0;
    end else begin
      rdData   <= {rdValid, rdPar, rdA4, rdTag};
      rdParErr <= rdValid & (rdPar ^ (^{rdA4, rdTag}));
    end
  end

endmodule

// File: rtl/l1_rev_dir.sv
module l1_rev_dir
  import l1_rev_dir_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int CORE_W  = 1,
  parameter int L1WAY_W = 2,
  parameter int L2WAY_W = 4,
  parameter int SET_W   = 9,
  parameter int MASK_W  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [MASK_W-1:0]             bankMask,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [CORE_W-1:0]             reqCore,
  input  logic [L1WAY_W-1:0]            reqL1Way,
  input  logic [L2WAY_W-1:0]            reqL2Way,
  input  logic                          reqIside,
  input  logic                          invAll,
  input  logic                          invValid,
  input  logic                          invIside,
  input  logic [$clog2(MASK_W):0]       invBank,
  input  logic                          invRow,
  input  logic [1:0]                    invPanel,
  input  logic [CORE_W+L1WAY_W:0]       invEntry,
  input  logic                          rdIside,
  input  logic [$clog2(MASK_W):0]       rdBank,
  input  logic                          rdRow,
  input  logic [1:0]                    rdPanel,
  input  logic [CORE_W+L1WAY_W:0]       rdEntry,
  output logic [SET_W+L2WAY_W+2:0]      rdData,
  output logic                          rdParErr
);

  localparam int BANK_W = $clog2(MASK_W) + 1;
  localparam int SLOT_W = CORE_W + L1WAY_W + 1;
  localparam int TAG_W  = SET_W + L2WAY_W;
  localparam int LOC_W  = 1 + BANK_W + 1 + 2 + SLOT_W;

  dir_strobe_t            strobes;
  logic [BANK_W-1:0]      wrBank;
  logic                   wrRow;
  logic [1:0]             wrPanel;
  logic [SLOT_W-1:0]      wrSlot;
  logic [TAG_W+2:0]       wrWord;
  logic [LOC_W-1:0]       wrLoc;
  logic [LOC_W-1:0]       invLoc;
  logic [LOC_W-1:0]       rdLoc;
  logic [(1<<LOC_W)-1:0]  validBits;

  l1_rev_dir_ctrl #(
    .ADDR_W(ADDR_W), .CORE_W(CORE_W), .L1WAY_W(L1WAY_W),
    .L2WAY_W(L2WAY_W), .SET_W(SET_W), .MASK_W(MASK_W)
  ) u_ctrl (
    .bankMask(bankMask),
    .reqValid(reqValid),
    .reqAddr (reqAddr),
    .reqCore (reqCore),
    .reqL1Way(reqL1Way),
    .reqL2Way(reqL2Way),
    .reqIside(reqIside),
    .invAll  (invAll),
    .invValid(invValid),
    .strobes (strobes),
    .wrBank  (wrBank),
    .wrRow   (wrRow),
    .wrPanel (wrPanel),
    .wrSlot  (wrSlot),
    .wrWord  (wrWord)
  );

  assign wrLoc  = {reqIside, wrBank, wrRow, wrPanel, wrSlot};
  assign invLoc = {invIside, invBank, invRow, invPanel, invEntry};
  assign rdLoc  = {rdIside, rdBank, rdRow, rdPanel, rdEntry};

  l1_rev_dir_store #(
    .LOC_W(LOC_W), .TAG_W(TAG_W)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrLoc    (wrLoc),
    .wrWord   (wrWord),
    .invLoc   (invLoc),
    .rdLoc    (rdLoc),
    .rdData   (rdData),
    .rdParErr (rdParErr),
    .validBits(validBits)
  );

endmodule

// File: rtl/l1_rev_dir_chk.sv
module l1_rev_dir_chk
  import l1_rev_dir_pkg::*;
#(
  parameter int LOC_W  = 11,
  parameter int WORD_W = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   invAll,
  input dir_strobe_t            strobes,
  input logic [LOC_W-1:0]       wrLoc,
  input logic [LOC_W-1:0]       invLoc,
  input logic [WORD_W-1:0]      wrWord,
  input logic [(1<<LOC_W)-1:0]  validBits,
  input logic                   rdParErr
);

  // R9: one cycle after invAll no valid bit is left
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> (validBits == '0));

  // R9: invAll suppresses the other strobes
  a_r9_priority: assert property (@(posedge clk) disable iff (!rstN)
    invAll |-> (!strobes.wrEn && !strobes.invEn));

  // R7: a write leaves its entry valid
  a_r7_write_sets: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> validBits[$past(wrLoc)]);

  // R8: an invalidate that does not collide with a write clears its entry
  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.invEn && !(strobes.wrEn && (wrLoc == invLoc))) |=> !validBits[$past(invLoc)]);

  // R2: written words carry even parity over bits 14:0
  a_r2_word_parity: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> ((^wrWord[WORD_W-2:0]) == 1'b0));

  // R1: written words are marked valid
  a_r1_valid_bit: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> wrWord[WORD_W-1]);

  // R2: entries written by the block never report a parity error
  a_r2_no_parerr: assert property (@(posedge clk) disable iff (!rstN)
    !rdParErr);

endmodule

bind l1_rev_dir l1_rev_dir_chk #(
  .LOC_W(LOC_W), .WORD_W(TAG_W + 3)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .invAll   (invAll),
  .strobes  (strobes),
  .wrLoc    (wrLoc),
  .invLoc   (invLoc),
  .wrWord   (wrWord),
  .validBits(validBits),
  .rdParErr (rdParErr)
);

// File: tb/l1_rev_dir_tb.sv
`timescale 1ns/1ps
module l1_rev_dir_tb;

  localparam int LOC_W = 11;

  typedef struct packed {
    logic [39:0] addr;
    logic        core;
    logic [1:0]  way;
    logic [3:0]  l2w;
    logic        side;
    logic [3:0]  mask;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{40'h12_3456_7890, 1'b0, 2'd1, 4'h5, 1'b0, 4'hF},
    '{40'h00_0003_FE30, 1'b1, 2'd3, 4'hA, 1'b1, 4'hF},
    '{40'hAB_CDEF_01D0, 1'b0, 2'd2, 4'h3, 1'b0, 4'h5},
    '{40'h00_0001_2350, 1'b1, 2'd0, 4'hF, 1'b1, 4'h6},
    '{40'h55_5555_5540, 1'b0, 2'd1, 4'h0, 1'b0, 4'h8},
    '{40'h00_0000_06F0, 1'b1, 2'd2, 4'h7, 1'b1, 4'h1},
    '{40'h7F_FFFF_FFFF, 1'b1, 2'd3, 4'hC, 1'b0, 4'h7},
    '{40'h00_0000_0000, 1'b0, 2'd0, 4'h1, 1'b1, 4'h0}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  bankMask = 4'hF;
  logic        reqValid = 0;
  logic [39:0] reqAddr = '0;
  logic        reqCore = 0;
  logic [1:0]  reqL1Way = '0;
  logic [3:0]  reqL2Way = '0;
  logic        reqIside = 0;
  logic        invAll = 0;
  logic        invValid = 0;
  logic        invIside = 0;
  logic [2:0]  invBank = '0;
  logic        invRow = 0;
  logic [1:0]  invPanel = '0;
  logic [3:0]  invEntry = '0;
  logic        rdIside = 0;
  logic [2:0]  rdBank = '0;
  logic        rdRow = 0;
  logic [1:0]  rdPanel = '0;
  logic [3:0]  rdEntry = '0;
  logic [15:0] rdData;
  logic        rdParErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] shadow [int];

  always #2.5 clk = ~clk;

  l1_rev_dir u_dut (
    .clk(clk), .rstN(rstN), .bankMask(bankMask),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqCore(reqCore),
    .reqL1Way(reqL1Way), .reqL2Way(reqL2Way), .reqIside(reqIside),
    .invAll(invAll), .invValid(invValid), .invIside(invIside),
    .invBank(invBank), .invRow(invRow), .invPanel(invPanel), .invEntry(invEntry),
    .rdIside(rdIside), .rdBank(rdBank), .rdRow(rdRow), .rdPanel(rdPanel),
    .rdEntry(rdEntry), .rdData(rdData), .rdParErr(rdParErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] shadowAt(input int key);
    return shadow.exists(key) ? shadow[key] : 16'h0000;
  endfunction

  // Reference placement and word, from R1..R6.
  task automatic model(input vec_t v, input logic [3:0] mask,
                       output logic [LOC_W-1:0] loc, output logic [15:0] word);
    int cnt;
    int lo;
    int hi;
    logic [2:0] bank;
    logic [8:0] setIx;
    logic [12:0] tag;
    logic a4;
    cnt = $countones(mask);
    lo = -1;
    hi = 0;
    for (int i = 0; i < 4; i++) if (mask[i]) begin
      if (lo < 0) lo = i;
      hi = i;
    end
    if (cnt == 1) begin
      bank = {2'(lo), v.addr[6]};
      setIx = v.addr[15:7];
    end else if (cnt == 2) begin
      bank = {(v.addr[7] ? 2'(hi) : 2'(lo)), v.addr[6]};
      setIx = v.addr[16:8];
    end else begin
      bank = v.addr[8:6];
      setIx = v.addr[17:9];
    end
    a4 = v.addr[4];
    tag = {setIx, v.l2w};
    loc = {v.side, bank, v.addr[5], v.addr[10:9], v.core, v.way, a4};
    word = {1'b1, (^tag) ^ a4, a4, tag};
  endtask

  task automatic setRead(input logic [LOC_W-1:0] loc);
    {rdIside, rdBank, rdRow, rdPanel, rdEntry} = loc;
  endtask

  task automatic readCheck(input logic [LOC_W-1:0] loc, input logic [15:0] exp, input string req);
    @(negedge clk);
    setRead(loc);
    @(negedge clk);
    chk(rdData === exp, req, 32'(rdData), 32'(exp));
    chk(rdParErr === 1'b0, "R2 parity flag", 32'(rdParErr), 32'h0);
  endtask

  task automatic driveWrite(input vec_t v);
    reqValid = 1;
    reqAddr  = v.addr;
    reqCore  = v.core;
    reqL1Way = v.way;
    reqL2Way = v.l2w;
    reqIside = v.side;
  endtask

  task automatic doWrite(input vec_t v);
    logic [LOC_W-1:0] loc;
    logic [15:0] w;
    @(negedge clk);
    bankMask = v.mask;
    driveWrite(v);
    model(v, v.mask, loc, w);
    shadow[int'(loc)] = w;
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [LOC_W-1:0] loc;
    logic [LOC_W-1:0] locFull;
    logic [LOC_W-1:0] loc0;
    logic [LOC_W-1:0] locNew;
    logic [15:0] w;
    vec_t v;

    repeat (4) @(negedge clk);
    rstN = 1;

    // R11: reset contents
    readCheck('0, 16'h0000, "R11 reset entry 0");
    readCheck(LOC_W'(11'h5A3), 16'h0000, "R11 reset entry 5A3");

    // Table walk: R1..R6 placement and format; cross-check full-interleave spot.
    for (int k = 0; k < 8; k++) begin
      v = VECS[k];
      doWrite(v);
      model(v, v.mask, loc, w);
      readCheck(loc, w, "R1/R3/R4/R5/R6 table entry");
      model(v, 4'hF, locFull, w);
      if (locFull != loc)
        readCheck(locFull, shadowAt(int'(locFull)), "R4/R5 mode shift, full-mode spot untouched");
    end

    // R7: sweep all 16 slots of the first entry's array
    model(VECS[0], VECS[0].mask, loc0, w);
    for (int s = 0; s < 16; s++) begin
      loc = {loc0[LOC_W-1:4], 4'(s)};
      readCheck(loc, shadowAt(int'(loc)), "R7 neighbour slots");
    end

    // R8: invalidate one entry, fields stay, others stay
    @(negedge clk);
    invValid = 1;
    {invIside, invBank, invRow, invPanel, invEntry} = loc0;
    shadow[int'(loc0)][15] = 1'b0;
    @(negedge clk);
    invValid = 0;
    readCheck(loc0, shadowAt(int'(loc0)), "R8 invalidate clears valid only");
    model(VECS[1], VECS[1].mask, loc, w);
    readCheck(loc, shadowAt(int'(loc)), "R8 other entry kept");

    // R8: write and invalidate the same entry together -> write wins
    @(negedge clk);
    bankMask = VECS[0].mask;
    driveWrite(VECS[0]);
    invValid = 1;
    {invIside, invBank, invRow, invPanel, invEntry} = loc0;
    model(VECS[0], VECS[0].mask, loc, w);
    shadow[int'(loc)] = w;
    @(negedge clk);
    reqValid = 0;
    invValid = 0;
    readCheck(loc0, w, "R8 write beats invalidate");

    // R10: read and write the same fresh slot in one cycle
    v = '{40'h00_00AB_C410, 1'b1, 2'd1, 4'h9, 1'b0, 4'hF};
    model(v, 4'hF, locNew, w);
    @(negedge clk);
    bankMask = 4'hF;
    driveWrite(v);
    setRead(locNew);
    @(negedge clk);
    reqValid = 0;
    chk(rdData === shadowAt(int'(locNew)), "R10 read returns old contents",
        32'(rdData), 32'(shadowAt(int'(locNew))));
    shadow[int'(locNew)] = w;
    @(negedge clk);
    chk(rdData === w, "R10 new contents next cycle", 32'(rdData), 32'(w));

    // R9: invAll together with a write to another fresh slot
    v = '{40'h00_0FF0_0E20, 1'b0, 2'd3, 4'h2, 1'b1, 4'hF};
    model(v, 4'hF, loc, w);
    @(negedge clk);
    driveWrite(v);
    invAll = 1;
    foreach (shadow[key]) shadow[key][15] = 1'b0;
    @(negedge clk);
    reqValid = 0;
    invAll = 0;
    readCheck(loc, shadowAt(int'(loc)), "R9 write suppressed by invAll");
    for (int k = 0; k < 8; k++) begin
      model(VECS[k], VECS[k].mask, loc, w);
      readCheck(loc, shadowAt(int'(loc)), "R9 valid cleared on both sides");
    end
    readCheck(locNew, shadowAt(int'(locNew)), "R9 valid cleared");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule